// File: doc/BRIEF.md
# Saturating Vector Multiply-High-Add Unit

This block is a SIMD datapath for fixed-point signal work. It takes three 128-bit operand vectors, A, B and C, each split into eight signed 16-bit lanes, and returns one 128-bit result vector. Each lane forms the full signed product of its A and B halfwords. It keeps that product scaled down by 15 bits, which is a Q15 multiply, and adds the C halfword. It then clamps the sum into the signed 16-bit range. A status bit records that some lane was clamped. The bit stays set until software clears it.

An operation arrives as a 32-bit instruction word with its three operand vectors and a valid strobe. The unit is fully pipelined, so it always accepts a request. It returns the result two clock edges after it accepts the request. The result carries the target register field copied from the instruction. The unit only executes when the vector-enable input is high. With vector-enable low, it raises a one-cycle unavailable fault at the same point in the pipeline and leaves the result and the status untouched. Fetching registers and decoding other instructions are left to the surrounding pipeline.

Top module: `vmha_unit`

## Requirements
- R1: `req_ready` is always 1. A request is taken when `req_valid` is 1 and the instruction matches. If it is taken with `vec_en` = 1, `res_valid` is 1 for exactly one cycle, two rising edges after the accepting edge. A new request may be taken on every cycle.
- R2: For lane i, the result is `clamp(((A_i * B_i) >>> 15) + C_i)`, with all values signed. The shift is arithmetic, so it rounds toward minus infinity.
- R3: A lane sum above 32767 gives 32767 (0x7FFF).
- R4: A lane sum below -32768 gives -32768 (0x8000).
- R5: The edge that presents an executed result with at least one clamped lane also sets `sat_sticky`. `sat_sticky` never rises at any other time.
- R6: `sat_sticky` stays 1 across later operations that do not clamp. It returns to 0 on the edge after a cycle with `sat_clr` = 1. If a clamping result lands on the same edge as the clear, `sat_sticky` stays 1.
- R7: A request taken with `vec_en` = 0 gives `unavail_fault` = 1 for one cycle, two edges later. In that cycle `res_valid` is 0, and `res_data`, `res_tgt` and `sat_sticky` keep their previous values.
- R8: The instruction matches when bits [31:26] equal 4 and bits [5:0] equal 32. A request that does not match produces neither a result nor a fault.
- R9: `res_tgt` carries instruction bits [25:21] of the operation whose result is presented.
- R10: Lane 0 occupies bits [127:112] of every vector, and lane 7 occupies bits [15:0].
- R11: While `rst_n` is low at a rising edge, `res_valid`, `unavail_fault` and `sat_sticky` are 0, and `res_data` and `res_tgt` are all zeros.
- R12: A = -32768 and B = -32768 give a scaled product of 32768. With C = 0 the lane returns 32767 and sets `sat_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Operation request strobe |
| req_ready | output | 1 | Request acceptance, always 1 |
| req_instr | input | 32 | Instruction word of the request |
| req_a | input | 128 | Operand vector A, lane 0 in the top halfword |
| req_b | input | 128 | Operand vector B |
| req_c | input | 128 | Addend vector C |
| vec_en | input | 1 | Vector unit enable, sampled with the request |
| sat_clr | input | 1 | Software clear of the sticky saturation bit |
| res_valid | output | 1 | Result strobe |
| res_data | output | 128 | Result vector |
| res_tgt | output | 5 | Target register field of the presented result |
| unavail_fault | output | 1 | Unavailable fault strobe |
| sat_sticky | output | 1 | Sticky saturation status |

## Verification
The assertions check the pipeline contract on every cycle:
- a matching request with the unit enabled always yields a result two edges later;
- a disabled request yields a fault in that slot and never a result;
- a request that does not match, or an idle cycle, yields neither;
- `res_data` holds during a fault;
- the saturation bit never drops without a clear and only rises together with a result.

Only the bench's scenarios can show that the lane values are right and land in the correct halfword. They sweep a grid of boundary values over every A, B, C combination per lane, then run pseudo-random operands against an arithmetic model. They also cover the extreme-product corner, a set and a clear landing on the same edge, and the back-to-back throughput.

// File: rtl/vmha_pkg.sv
// Shared constants and types for the multiply-high-add unit.
// Assumes the 32-bit four-register instruction layout: primary opcode on
// top, four 5-bit register fields, extended opcode in the low six bits.
package vmha_pkg;
    localparam int PRIM_W  = 6;
    localparam int EXT_W   = 6;
    localparam int REG_W   = 5;
    localparam logic [PRIM_W-1:0] PRIM_OP = 6'd4;
    localparam logic [EXT_W-1:0]  EXT_OP  = 6'd32;

    // Control word travelling alongside the first pipeline stage.
    typedef struct packed {
        logic             run;      // operation executes
        logic             blocked;  // operation refused, unit disabled
        logic [REG_W-1:0] tgt;      // target register field
    } vmha_s1_t;
endpackage

// File: rtl/vmha_lane_mul.sv
// First stage of one lane: registers the full signed product of A and B
// together with the addend. Assumes two's complement operands; the product
// register is only loaded for operations that execute.
module vmha_lane_mul #(
    parameter int LANE_W = 16,
    parameter int PROD_W = 2 * LANE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic signed [LANE_W-1:0] a,
    input  logic signed [LANE_W-1:0] b,
    input  logic signed [LANE_W-1:0] c,
    output logic signed [PROD_W-1:0] prod_q,
    output logic signed [LANE_W-1:0] c_q
);
    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;

    // Sign-extend both factors to product width before multiplying.
    always_comb begin
        a_ext = PROD_W'(a);
        b_ext = PROD_W'(b);
    end

    // Capture product and addend for the second stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            c_q    <= '0;
        end else if (load) begin
            prod_q <= a_ext * b_ext;
            c_q    <= c;
        end
    end
endmodule

// File: rtl/vmha_lane_sat.sv
// Second stage of one lane, combinational: takes the product's upper bits
// (an arithmetic shift right by LANE_W-1), adds the sign-extended addend at
// a width that cannot overflow, and clamps to the signed lane range.
module vmha_lane_sat #(
    parameter int LANE_W = 16,
    parameter int PROD_W = 2 * LANE_W
) (
    input  logic signed [PROD_W-1:0] prod,
    input  logic signed [LANE_W-1:0] c,
    output logic        [LANE_W-1:0] res,
    output logic                     sat_hi,
    output logic                     sat_lo
);
    localparam int SHIFT = LANE_W - 1;
    localparam int HI_W  = PROD_W - SHIFT;
    localparam int SUM_W = HI_W + 1;
    localparam logic signed [SUM_W-1:0] MAXV =
        {{(SUM_W - LANE_W + 1){1'b0}}, {(LANE_W - 1){1'b1}}};
    localparam logic signed [SUM_W-1:0] MINV =
        {{(SUM_W - LANE_W + 1){1'b1}}, {(LANE_W - 1){1'b0}}};

    logic signed [HI_W-1:0]  hi;
    logic signed [SUM_W-1:0] sum;

    // Scale the product and add the addend one bit wider than needed.
    always_comb begin
        hi  = prod[PROD_W-1:SHIFT];
        sum = $signed({hi[HI_W-1], hi}) + SUM_W'(c);
    end

    // Detect range excursions and select the clamped value.
    always_comb begin
        sat_hi = (sum > MAXV);
        sat_lo = (sum < MINV);
        if (sat_hi) begin
            res = MAXV[LANE_W-1:0];
        end else if (sat_lo) begin
            res = MINV[LANE_W-1:0];
        end else begin
            res = sum[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/vmha_decode.sv
// Instruction recogniser: flags the multiply-high-add encoding and extracts
// the target register field. Source register fields are not needed here,
// because the operands arrive as vectors.
module vmha_decode
    import vmha_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               match,
    output logic [REG_W-1:0]   tgt
);
    localparam int TGT_HI = INSTR_W - PRIM_W - 1;
    localparam int SRC_HI = TGT_HI - REG_W;

    logic unused_src_fields;

    // Compare both opcode fields and pick out the target field.
    always_comb begin
        match = (instr[INSTR_W-1 -: PRIM_W] == PRIM_OP) &&
                (instr[EXT_W-1:0] == EXT_OP);
        tgt   = instr[TGT_HI -: REG_W];
        unused_src_fields = ^instr[SRC_HI:EXT_W];
    end
endmodule

// File: rtl/vmha_unit.sv
// Top of the saturating multiply-high-add unit. It is a two-stage pipeline:
// stage 1 registers the lane products, stage 2 registers the clamped sums.
// It accepts a request every cycle. The vector enable is sampled with the
// request. The sticky saturation bit is kept here; a clamping result beats a
// clear that lands on the same edge.
module vmha_unit
    import vmha_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int LANE_W  = 16,
    parameter int INSTR_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [INSTR_W-1:0]       req_instr,
    input  logic [LANES*LANE_W-1:0]  req_a,
    input  logic [LANES*LANE_W-1:0]  req_b,
    input  logic [LANES*LANE_W-1:0]  req_c,
    input  logic                     vec_en,
    input  logic                     sat_clr,
    output logic                     res_valid,
    output logic [LANES*LANE_W-1:0]  res_data,
    output logic [REG_W-1:0]         res_tgt,
    output logic                     unavail_fault,
    output logic                     sat_sticky
);
    localparam int VEC_W  = LANES * LANE_W;
    localparam int PROD_W = 2 * LANE_W;

    logic               op_match;
    logic [REG_W-1:0]   op_tgt;
    logic               take;
    vmha_s1_t           s1_q;
    logic [VEC_W-1:0]   lane_res;
    logic [LANES-1:0]   lane_hi;
    logic [LANES-1:0]   lane_lo;
    logic               any_sat;

    vmha_decode #(.INSTR_W(INSTR_W)) u_decode (
        .instr (req_instr),
        .match (op_match),
        .tgt   (op_tgt)
    );

    // Fully pipelined: a request is always accepted.
    always_comb begin
        req_ready = 1'b1;
        take      = req_valid && op_match;
    end

    // Stage 1 control: note whether the taken operation runs or faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else begin
            s1_q.run     <= take && vec_en;
            s1_q.blocked <= take && !vec_en;
            s1_q.tgt     <= op_tgt;
        end
    end

    // One multiply and one clamp per lane; lane 0 sits in the top halfword.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = (LANES - 1 - g) * LANE_W;
        logic signed [PROD_W-1:0] prod_q;
        logic signed [LANE_W-1:0] c_q;

        vmha_lane_mul #(.LANE_W(LANE_W), .PROD_W(PROD_W)) u_mul (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (take && vec_en),
            .a      (req_a[LO +: LANE_W]),
            .b      (req_b[LO +: LANE_W]),
            .c      (req_c[LO +: LANE_W]),
            .prod_q (prod_q),
            .c_q    (c_q)
        );

        vmha_lane_sat #(.LANE_W(LANE_W), .PROD_W(PROD_W)) u_sat (
            .prod   (prod_q),
            .c      (c_q),
            .res    (lane_res[LO +: LANE_W]),
            .sat_hi (lane_hi[g]),
            .sat_lo (lane_lo[g])
        );
    end

    // Any lane clamped in the operation now leaving stage 1.
    always_comb begin
        any_sat = |(lane_hi | lane_lo);
    end

    // Stage 2: present results and fault strobes; hold data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            unavail_fault <= 1'b0;
            res_data      <= '0;
            res_tgt       <= '0;
        end else begin
            res_valid     <= s1_q.run;
            unavail_fault <= s1_q.blocked;
            if (s1_q.run) begin
                res_data <= lane_res;
                res_tgt  <= s1_q.tgt;
            end
        end
    end

    // Sticky saturation status: set by a clamping result, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_sticky <= 1'b0;
        end else begin
            sat_sticky <= (sat_sticky && !sat_clr) || (s1_q.run && any_sat);
        end
    end
endmodule

// File: rtl/vmha_chk.sv
// Protocol checker for vmha_unit, bound to every instance. It watches only
// ports and relates requests to the strobes two edges later.
module vmha_chk
    import vmha_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter int INSTR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [INSTR_W-1:0] req_instr,
    input logic               vec_en,
    input logic               sat_clr,
    input logic               res_valid,
    input logic [VEC_W-1:0]   res_data,
    input logic               unavail_fault,
    input logic               sat_sticky
);
    logic legal;
    logic unused_chk_bits;

    // Recognise a matching request from the port values.
    always_comb begin
        legal = req_valid &&
                (req_instr[INSTR_W-1 -: PRIM_W] == PRIM_OP) &&
                (req_instr[EXT_W-1:0] == EXT_OP);
        unused_chk_bits = ^req_instr[INSTR_W-PRIM_W-1:EXT_W];
    end

    AST_RESULT_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && vec_en) |-> ##2 (res_valid && !unavail_fault)); // R1
    AST_FAULT_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && !vec_en) |-> ##2 (unavail_fault && !res_valid)); // R7
    AST_FAULT_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        unavail_fault |-> $stable(res_data)); // R7
    AST_NO_OUTPUT_UNMATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |-> ##2 (!res_valid && !unavail_fault)); // R8
    AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_sticky && !sat_clr) |=> sat_sticky); // R6
    AST_SAT_RISES_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_sticky) |-> res_valid); // R5
endmodule

bind vmha_unit vmha_chk #(.VEC_W(LANES*LANE_W), .INSTR_W(INSTR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_instr     (req_instr),
    .vec_en        (vec_en),
    .sat_clr       (sat_clr),
    .res_valid     (res_valid),
    .res_data      (res_data),
    .unavail_fault (unavail_fault),
    .sat_sticky    (sat_sticky)
);

// File: tb/vmha_unit_tb.sv
// Self-checking bench: a boundary-value sweep of every lane, pseudo-random
// operands, and directed corner cases, all against an arithmetic model.
module vmha_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LN = 8;
    localparam int LW = 16;
    localparam int VW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [31:0]   req_instr;
    logic [VW-1:0] req_a, req_b, req_c;
    logic          vec_en;
    logic          sat_clr;
    logic          res_valid;
    logic [VW-1:0] res_data;
    logic [4:0]    res_tgt;
    logic          unavail_fault;
    logic          sat_sticky;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit exp_sat = 0;
    int op_a[LN], op_b[LN], op_c[LN];
    int vals[8] = '{-32768, -32767, -16384, -1, 0, 1, 16383, 32767};
    int seed = 32'h1234_5678;

    vmha_unit #(.LANES(LN), .LANE_W(LW), .INSTR_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_instr(req_instr), .req_a(req_a), .req_b(req_b), .req_c(req_c),
        .vec_en(vec_en), .sat_clr(sat_clr), .res_valid(res_valid),
        .res_data(res_data), .res_tgt(res_tgt), .unavail_fault(unavail_fault),
        .sat_sticky(sat_sticky)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            finish_up();
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_instr(input logic [4:0] t,
                                             input logic [5:0] prim,
                                             input logic [5:0] ext);
        return {prim, t, 5'd1, 5'd2, 5'd3, ext};
    endfunction

    // Model of one lane: scale, add, clamp.
    function automatic int ref_lane(input int a, input int b, input int c,
                                    output bit hi, output bit lo);
        longint p, s;
        p  = longint'(a) * longint'(b);
        s  = (p >>> 15) + longint'(c);
        hi = (s > 32767);
        lo = (s < -32768);
        if (hi) return 32767;
        if (lo) return -32768;
        return int'(s);
    endfunction

    function automatic int lane_of(input logic [VW-1:0] v, input int j);
        return int'($signed(v[(LN-1-j)*LW +: LW]));
    endfunction

    function automatic int next_rand();
        seed = seed * 1664525 + 1013904223;
        return seed;
    endfunction

    task automatic load_ops();
        for (int j = 0; j < LN; j++) begin
            req_a[(LN-1-j)*LW +: LW] = op_a[j][LW-1:0];
            req_b[(LN-1-j)*LW +: LW] = op_b[j][LW-1:0];
            req_c[(LN-1-j)*LW +: LW] = op_c[j][LW-1:0];
        end
    endtask

    // Issue one operation, wait for its slot, check every output.
    task automatic run_op(input bit en, input logic [31:0] instr, input bit clr);
        logic [VW-1:0] prev;
        logic [4:0]    prev_tgt;
        bit legal, any, h, l;
        int r;
        @(negedge clk);
        chk(!res_valid && !unavail_fault, "R1", "strobe idle between ops",
            {res_valid, unavail_fault}, 0);
        prev = res_data;
        prev_tgt = res_tgt;
        load_ops();
        req_instr = instr;
        vec_en = en;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        sat_clr = clr;
        @(negedge clk);
        sat_clr = 1'b0;
        legal = (instr[31:26] == 6'd4) && (instr[5:0] == 6'd32);
        any = 0;
        if (legal && en) begin
            chk(res_valid && !unavail_fault, "R1", "result strobe after two edges",
                {res_valid, unavail_fault}, 2);
            for (int j = 0; j < LN; j++) begin
                r = ref_lane(op_a[j], op_b[j], op_c[j], h, l);
                any |= h | l;
                chk(lane_of(res_data, j) == r, h ? "R3" : (l ? "R4" : "R2"),
                    "lane value", lane_of(res_data, j), r);
            end
            chk(res_tgt == instr[25:21], "R9", "target field", res_tgt, instr[25:21]);
        end else if (legal) begin
            chk(unavail_fault && !res_valid, "R7", "fault strobe",
                {res_valid, unavail_fault}, 1);
            chk(res_data == prev && res_tgt == prev_tgt, "R7", "result held on fault",
                res_data[63:0], prev[63:0]);
        end else begin
            chk(!res_valid && !unavail_fault, "R8", "unmatched request silent",
                {res_valid, unavail_fault}, 0);
            chk(res_data == prev, "R8", "result held on unmatched",
                res_data[63:0], prev[63:0]);
        end
        exp_sat = (exp_sat && !clr) || any;
        chk(sat_sticky == exp_sat, clr ? "R6" : "R5", "sticky saturation",
            sat_sticky, exp_sat);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        exp_sat = 0;
        chk(sat_sticky == 1'b0, "R6", "software clear", sat_sticky, 0);
    endtask

    task automatic fill(input int a, input int b, input int c);
        for (int j = 0; j < LN; j++) begin
            op_a[j] = a; op_b[j] = b; op_c[j] = c;
        end
    endtask

    initial begin
        bit h, l;
        int r;
        rst_n = 1'b0; req_valid = 1'b0; req_instr = '0; vec_en = 1'b1;
        sat_clr = 1'b0; req_a = '0; req_b = '0; req_c = '0;
        repeat (4) @(negedge clk);
        chk(!res_valid && !unavail_fault && !sat_sticky && res_data == '0 &&
            res_tgt == '0, "R11", "reset state", res_data[63:0], 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "always ready", req_ready, 1);

        // R12: extreme product corner.
        fill(-32768, -32768, 0);
        run_op(1, mk_instr(5'd9, 6'd4, 6'd32), 0);
        chk(res_data[127:112] == 16'h7fff && sat_sticky, "R12", "extreme product clamps",
            res_data[127:112], 16'h7fff);

        // R7: disabled unit, sticky bit and data must hold.
        fill(100, 200, 300);
        run_op(0, mk_instr(5'd3, 6'd4, 6'd32), 0);

        // R6: clear, then set-beats-clear, then hold over a quiet op.
        pulse_clr();
        fill(32767, 32767, 32767);
        run_op(1, mk_instr(5'd4, 6'd4, 6'd32), 1);
        chk(sat_sticky == 1'b1, "R6", "set wins over clear", sat_sticky, 1);
        fill(10, 10, 10);
        run_op(1, mk_instr(5'd5, 6'd4, 6'd32), 0);
        chk(sat_sticky == 1'b1, "R6", "sticky across quiet op", sat_sticky, 1);
        pulse_clr();

        // R8: wrong primary and wrong extended opcode.
        run_op(1, mk_instr(5'd6, 6'd5, 6'd32), 0);
        run_op(1, mk_instr(5'd7, 6'd4, 6'd33), 0);

        // R10: distinct lanes land in their own halfwords.
        for (int j = 0; j < LN; j++) begin
            op_a[j] = (j + 1) * 1000; op_b[j] = 16384; op_c[j] = j;
        end
        run_op(1, mk_instr(5'd8, 6'd4, 6'd32), 0);
        chk($signed(res_data[127:112]) == 500, "R10", "lane 0 in top halfword",
            $signed(res_data[127:112]), 500);
        chk($signed(res_data[15:0]) == 4007, "R10", "lane 7 in bottom halfword",
            $signed(res_data[15:0]), 4007);

        // R1: back-to-back requests stream one result per cycle.
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                chk(res_valid == 1'b1, "R1", "burst result strobe", res_valid, 1);
                chk(res_tgt == 5'(k - 2), "R1", "burst order", res_tgt, k - 2);
                for (int j = 0; j < LN; j++) begin
                    r = ref_lane(1000 * (k - 1) + j, 20000, -100 * (k - 2), h, l);
                    chk(lane_of(res_data, j) == r, "R1", "burst lane value",
                        lane_of(res_data, j), r);
                end
            end
            if (k < 4) begin
                for (int j = 0; j < LN; j++) begin
                    op_a[j] = 1000 * (k + 1) + j; op_b[j] = 20000; op_c[j] = -100 * k;
                end
                load_ops();
                req_instr = mk_instr(5'(k), 6'd4, 6'd32);
                vec_en = 1'b1;
                req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
        end

        // R2/R3/R4: every boundary triple on every lane.
        for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
                for (int ic = 0; ic < 8; ic++) begin
                    for (int j = 0; j < LN; j++) begin
                        op_a[j] = vals[(ia + j) % 8];
                        op_b[j] = vals[ib];
                        op_c[j] = vals[(ic + j) % 8];
                    end
                    run_op(1, mk_instr(5'(ia * 8 + ic), 6'd4, 6'd32), ic == 7);
                end
            end
        end

        // Pseudo-random operands, occasional disable, clear and bad opcode.
        for (int n = 0; n < 1000; n++) begin
            int ctl;
            for (int j = 0; j < LN; j++) begin
                op_a[j] = int'($signed(16'(next_rand() >>> 16)));
                op_b[j] = int'($signed(16'(next_rand() >>> 16)));
                op_c[j] = int'($signed(16'(next_rand() >>> 16)));
            end
            ctl = next_rand() >>> 20;
            run_op((ctl & 7) != 0, mk_instr(5'(ctl >>> 3),
                   ((ctl >>> 8) & 15) == 0 ? 6'd6 : 6'd4, 6'd32), ((ctl >>> 4) & 7) == 0);
        end

        finish_up();
    end
endmodule